// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a simple bus-organised processor. An internal control store holds one microinstruction per address. Each microinstruction carries a horizontal control field, with one bit for each datapath strobe. The block presents the field of the current word on its outputs. A 6-bit micro-program counter picks the word. Each cycle, a next-address unit chooses the counter's next value from four sources:
- the incremented counter;
- the start address of the routine for the opcode on the instruction-register input;
- a branch target, taken when a selected condition bit is set;
- address zero, where the fetch routine lives.

A microinstruction may also mark itself as waiting for memory. The counter then holds until the memory-done input is high.

The datapath sits outside the block. It loads the instruction register on the `ir_in` strobe of the third fetch step. That same step dispatches on `opcode_i`, so the datapath must drive the new opcode while that step is current. Condition flags arrive on `cond_i`. The control store holds these routines:
- fetch;
- an add with an autoincremented memory source;
- a register-indirect load;
- a branch-if-negative.

Any opcode without a routine sends the sequencer back to fetch and latches a sticky illegal flag.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_ni` is low: `upc_o` is 0, `illegal_o` is 0, and `ctrl_o` shows the first fetch word (`pc_out|mar_in|mem_rd|sel_four|alu_add|z_in`).
- R2: A microinstruction whose sequencing code is "next" advances `upc_o` by one on the following clock edge.
- R3: A microinstruction that waits for memory (addresses 1, 10 and 17) holds `upc_o` and repeats its control word for as long as `mfc_i` is low. `upc_o` advances on the first edge at which `mfc_i` is high, including when `mfc_i` is already high in that step's first cycle.
- R4: `mfc_i` has no effect on the sequence when the current microinstruction does not wait for memory.
- R5: At address 2 (the dispatch step), the next address comes from `opcode_i`: opcode 1 goes to 8, opcode 2 goes to 16, opcode 3 goes to 24.
- R6: Address 24 branches on `cond_i[0]` (negative flag). If the bit is 1, the next address is 26. If it is 0, the next address is 25.
- R7: A microinstruction marked End (addresses 12, 18, 25, 28) returns `upc_o` to 0 on the next edge.
- R8: An opcode other than 1, 2 or 3 at the dispatch step makes the next address 0 and sets `illegal_o` from the next cycle. The flag then stays set until reset.
- R9: Control bit positions in `ctrl_o`:

  | Bit | Signal | Bit | Signal | Bit | Signal |
  |---|---|---|---|---|---|
  | 0 | pc_out | 5 | alu_add | 10 | ir_in |
  | 1 | pc_in | 6 | z_in | 11 | rs_out |
  | 2 | mar_in | 7 | z_out | 12 | rs_in |
  | 3 | mem_rd | 8 | y_in | 13 | rd_out |
  | 4 | sel_four | 9 | mdr_out | 14 | rd_in |

  The fetch routine is:
  - address 0 as in R1;
  - address 1: `z_out|pc_in|y_in`;
  - address 2: `mdr_out|ir_in`.
- R10: The add routine is:
  - address 8: `rs_out|mar_in|mem_rd|sel_four|alu_add|z_in`;
  - address 9: `z_out|rs_in`;
  - address 10: `rd_out|y_in`;
  - address 11: `mdr_out|alu_add|z_in`;
  - address 12: `z_out|rd_in`.
- R11: The load routine is:
  - address 16: `rs_out|mar_in|mem_rd`;
  - address 17: all zero;
  - address 18: `mdr_out|rd_in`.

  The branch routine is:
  - addresses 24 and 25: all zero;
  - address 26: `pc_out|y_in`;
  - address 27: `alu_add|z_in`;
  - address 28: `z_out|pc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode of the instruction being loaded into the instruction register |
| cond_i | input | 4 | Condition flags; bit 0 is the negative flag |
| mfc_i | input | 1 | Memory function completed |
| ctrl_o | output | 15 | Horizontal control lines of the current microinstruction |
| upc_o | output | 6 | Current micro-program counter |
| illegal_o | output | 1 | Sticky flag for an undefined opcode |

## Verification
The bench releases memory-done after a random stall of zero to five cycles on each wait step.
- A design that ignored the wait bit would leave a wait step after one cycle. A design that waited for an extra edge would repeat the word one cycle too many. Either way, the emitted step list would not match the expected one.
- `mfc_i` is toggled at random on steps that do not wait, which exposes a sequencer that stalls on them.

Both outcomes of the negative-flag branch are driven, so a reversed or ignored condition shows up as a wrong address after step 24. Undefined opcodes, including 0 and 15, are mixed among legal ones. A flag that fails to latch, or clears on the next legal instruction, is caught, and so is a dispatch that falls through to address 3.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UPC_W  = 6;
  localparam int CTRL_W = 15;
  localparam int OPC_W  = 4;
  localparam int CC_W   = 4;
  localparam int CSEL_W = $clog2(CC_W);

  typedef enum logic [1:0] {
    SEQ_NEXT   = 2'd0,
    SEQ_BRANCH = 2'd1,
    SEQ_DISP   = 2'd2,
    SEQ_END    = 2'd3
  } seq_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic              wmfc;
    seq_e              seq;
    logic [CSEL_W-1:0] csel;
    logic [UPC_W-1:0]  target;
  } uword_t;

  localparam logic [CTRL_W-1:0] S_PC_OUT   = CTRL_W'(1) << 0;
  localparam logic [CTRL_W-1:0] S_PC_IN    = CTRL_W'(1) << 1;
  localparam logic [CTRL_W-1:0] S_MAR_IN   = CTRL_W'(1) << 2;
  localparam logic [CTRL_W-1:0] S_MEM_RD   = CTRL_W'(1) << 3;
  localparam logic [CTRL_W-1:0] S_SEL_FOUR = CTRL_W'(1) << 4;
  localparam logic [CTRL_W-1:0] S_ALU_ADD  = CTRL_W'(1) << 5;
  localparam logic [CTRL_W-1:0] S_Z_IN     = CTRL_W'(1) << 6;
  localparam logic [CTRL_W-1:0] S_Z_OUT    = CTRL_W'(1) << 7;
  localparam logic [CTRL_W-1:0] S_Y_IN     = CTRL_W'(1) << 8;
  localparam logic [CTRL_W-1:0] S_MDR_OUT  = CTRL_W'(1) << 9;
  localparam logic [CTRL_W-1:0] S_IR_IN    = CTRL_W'(1) << 10;
  localparam logic [CTRL_W-1:0] S_RS_OUT   = CTRL_W'(1) << 11;
  localparam logic [CTRL_W-1:0] S_RS_IN    = CTRL_W'(1) << 12;
  localparam logic [CTRL_W-1:0] S_RD_OUT   = CTRL_W'(1) << 13;
  localparam logic [CTRL_W-1:0] S_RD_IN    = CTRL_W'(1) << 14;

  localparam logic [UPC_W-1:0] A_FETCH = UPC_W'(0);
  localparam logic [UPC_W-1:0] A_ADD   = UPC_W'(8);
  localparam logic [UPC_W-1:0] A_LOAD  = UPC_W'(16);
  localparam logic [UPC_W-1:0] A_BRN   = UPC_W'(24);

  function automatic uword_t mk(logic [CTRL_W-1:0] c, logic w, seq_e s,
                                logic [CSEL_W-1:0] cs, logic [UPC_W-1:0] t);
    uword_t u;
    u.ctrl = c; u.wmfc = w; u.seq = s; u.csel = cs; u.target = t;
    return u;
  endfunction
endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] addr_i,
  output uword_t        word_o
);
  localparam int DEPTH = 1 << AW;

  always_comb begin
    word_o = mk('0, 1'b0, SEQ_END, '0, '0);  // unused slots return to fetch
    if (int'(addr_i) < DEPTH) begin
      case (addr_i)
        // fetch
        AW'(0):  word_o = mk(S_PC_OUT | S_MAR_IN | S_MEM_RD | S_SEL_FOUR | S_ALU_ADD | S_Z_IN,
                             1'b0, SEQ_NEXT, '0, '0);
        AW'(1):  word_o = mk(S_Z_OUT | S_PC_IN | S_Y_IN, 1'b1, SEQ_NEXT, '0, '0);
        AW'(2):  word_o = mk(S_MDR_OUT | S_IR_IN, 1'b0, SEQ_DISP, '0, '0);
        // add (rs)+, rd
        AW'(8):  word_o = mk(S_RS_OUT | S_MAR_IN | S_MEM_RD | S_SEL_FOUR | S_ALU_ADD | S_Z_IN,
                             1'b0, SEQ_NEXT, '0, '0);
        AW'(9):  word_o = mk(S_Z_OUT | S_RS_IN, 1'b0, SEQ_NEXT, '0, '0);
        AW'(10): word_o = mk(S_RD_OUT | S_Y_IN, 1'b1, SEQ_NEXT, '0, '0);
        AW'(11): word_o = mk(S_MDR_OUT | S_ALU_ADD | S_Z_IN, 1'b0, SEQ_NEXT, '0, '0);
        AW'(12): word_o = mk(S_Z_OUT | S_RD_IN, 1'b0, SEQ_END, '0, '0);
        // load (rs), rd
        AW'(16): word_o = mk(S_RS_OUT | S_MAR_IN | S_MEM_RD, 1'b0, SEQ_NEXT, '0, '0);
        AW'(17): word_o = mk('0, 1'b1, SEQ_NEXT, '0, '0);
        AW'(18): word_o = mk(S_MDR_OUT | S_RD_IN, 1'b0, SEQ_END, '0, '0);
        // branch if negative
        AW'(24): word_o = mk('0, 1'b0, SEQ_BRANCH, '0, AW'(26));
        AW'(25): word_o = mk('0, 1'b0, SEQ_END, '0, '0);
        AW'(26): word_o = mk(S_PC_OUT | S_Y_IN, 1'b0, SEQ_NEXT, '0, '0);
        AW'(27): word_o = mk(S_ALU_ADD | S_Z_IN, 1'b0, SEQ_NEXT, '0, '0);
        AW'(28): word_o = mk(S_Z_OUT | S_PC_IN, 1'b0, SEQ_END, '0, '0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int AW = UPC_W
) (
  input  logic [OW-1:0] opcode_i,
  output logic [AW-1:0] start_o,
  output logic          valid_o
);
  always_comb begin
    valid_o = 1'b1;
    start_o = A_FETCH;
    case (opcode_i)
      OW'(1):  start_o = A_ADD;
      OW'(2):  start_o = A_LOAD;
      OW'(3):  start_o = A_BRN;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ucode_next.sv
module ucode_next
  import ucode_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int CW = CC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  uword_t        word_i,
  input  logic [AW-1:0] start_i,
  input  logic          start_ok_i,
  input  logic [CW-1:0] cond_i,
  input  logic          mfc_i,
  output logic [AW-1:0] upc_o,
  output logic          illegal_o
);
  logic          stall;
  logic          cond_hit;
  logic [AW-1:0] upc_inc, upc_nxt;

  assign stall    = word_i.wmfc & ~mfc_i;
  assign cond_hit = cond_i[word_i.csel];
  assign upc_inc  = upc_o + AW'(1);

  always_comb begin
    unique case (word_i.seq)
      SEQ_NEXT:   upc_nxt = upc_inc;
      SEQ_BRANCH: upc_nxt = cond_hit ? word_i.target : upc_inc;
      SEQ_DISP:   upc_nxt = start_ok_i ? start_i : A_FETCH;
      default:    upc_nxt = A_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_o     <= A_FETCH;
      illegal_o <= 1'b0;
    end else begin
      if (!stall) upc_o <= upc_nxt;
      if (!stall && word_i.seq == SEQ_DISP && !start_ok_i) illegal_o <= 1'b1;
    end
  end

  a_r3_hold_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i.wmfc && !mfc_i) |=> $stable(upc_o));
  a_r2_step_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i.seq == SEQ_NEXT && !stall) |=> upc_o == $past(upc_o) + AW'(1));
  a_r6_branch_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i.seq == SEQ_BRANCH && cond_hit && !stall) |=> upc_o == $past(word_i.target));
  a_r7_end_to_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i.seq == SEQ_END && !stall) |=> upc_o == A_FETCH);
  a_r8_illegal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
  a_r8_illegal_to_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i.seq == SEQ_DISP && !start_ok_i) |=> (upc_o == A_FETCH && illegal_o));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int OW = OPC_W,
  parameter int CW = CC_W,
  parameter int NW = CTRL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] opcode_i,
  input  logic [CW-1:0] cond_i,
  input  logic          mfc_i,
  output logic [NW-1:0] ctrl_o,
  output logic [AW-1:0] upc_o,
  output logic          illegal_o
);
  uword_t        word;
  logic [AW-1:0] start;
  logic          start_ok;

  ucode_store #(.AW(AW)) i_store (
    .addr_i (upc_o),
    .word_o (word)
  );

  ucode_dispatch #(.OW(OW), .AW(AW)) i_dispatch (
    .opcode_i (opcode_i),
    .start_o  (start),
    .valid_o  (start_ok)
  );

  ucode_next #(.AW(AW), .CW(CW)) i_next (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .start_i    (start),
    .start_ok_i (start_ok),
    .cond_i     (cond_i),
    .mfc_i      (mfc_i),
    .upc_o      (upc_o),
    .illegal_o  (illegal_o)
  );

  assign ctrl_o = word.ctrl;

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (upc_o == '0 && !illegal_o));
endmodule

// File: tb/test_ucode_seq.sv
module test_ucode_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [3:0]  cond_i = '0;
  logic        mfc_i = 1'b0;
  logic [14:0] ctrl_o;
  logic [5:0]  upc_o;
  logic        illegal_o;

  int total = 0;
  int bad = 0;
  bit exp_ill = 1'b0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ucode_seq i_ucode_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .cond_i(cond_i),
    .mfc_i(mfc_i), .ctrl_o(ctrl_o), .upc_o(upc_o), .illegal_o(illegal_o)
  );

  function automatic logic [14:0] b(int n);
    return 15'(1) << n;
  endfunction

  // expected lines per address, from R9-R11 bit positions
  function automatic logic [14:0] exp_ctrl(int a);
    case (a)
      0:  return b(0) | b(2) | b(3) | b(4) | b(5) | b(6);
      1:  return b(7) | b(1) | b(8);
      2:  return b(9) | b(10);
      8:  return b(11) | b(2) | b(3) | b(4) | b(5) | b(6);
      9:  return b(7) | b(12);
      10: return b(13) | b(8);
      11: return b(9) | b(5) | b(6);
      12: return b(7) | b(14);
      16: return b(11) | b(2) | b(3);
      18: return b(9) | b(14);
      26: return b(0) | b(8);
      27: return b(5) | b(6);
      28: return b(7) | b(1);
      default: return '0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; checks each held cycle, then advances one negedge per cycle
  task automatic step(int a, bit waits, int stall, string tag);
    for (int i = 0; i <= (waits ? stall : 0); i++) begin
      chk(upc_o == 6'(a), {tag, " upc"}, upc_o, a);
      chk(ctrl_o == exp_ctrl(a), {tag, " R9 ctrl"}, ctrl_o, exp_ctrl(a));
      chk(illegal_o == exp_ill, "R8 illegal flag", illegal_o, exp_ill);
      mfc_i = waits ? (i == stall) : 1'($urandom % 2);
      @(negedge clk_i);
    end
  endtask

  task automatic run_instr(int opc, bit neg, int stall);
    opcode_i = 4'(opc);
    cond_i   = {3'($urandom), neg};
    step(0, 1'b0, 0, "R7 fetch0");
    step(1, 1'b1, stall, "R3 fetch1 wait");
    step(2, 1'b0, 0, "R2 fetch2");
    case (opc)
      1: begin
        step(8, 1'b0, 0, "R5 add start");
        step(9, 1'b0, 0, "R10 add");
        step(10, 1'b1, stall, "R3 add wait");
        step(11, 1'b0, 0, "R10 add");
        step(12, 1'b0, 0, "R10 add end");
      end
      2: begin
        step(16, 1'b0, 0, "R5 load start");
        step(17, 1'b1, stall, "R3 load wait");
        step(18, 1'b0, 0, "R11 load end");
      end
      3: begin
        step(24, 1'b0, 0, "R5 branch start");
        if (neg) begin
          step(26, 1'b0, 0, "R6 taken");
          step(27, 1'b0, 0, "R11 br");
          step(28, 1'b0, 0, "R11 br end");
        end else begin
          step(25, 1'b0, 0, "R6 not taken");
        end
      end
      default: exp_ill = 1'b1;
    endcase
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk_i);
    chk(upc_o == 6'd0, "R1 reset upc", upc_o, 0);
    chk(illegal_o == 1'b0, "R1 reset illegal", illegal_o, 0);
    chk(ctrl_o == exp_ctrl(0), "R1 reset ctrl", ctrl_o, exp_ctrl(0));
    rst_ni = 1'b1;
    // directed
    run_instr(1, 1'b0, 0);   // R3 mfc already high
    run_instr(2, 1'b1, 5);   // R3 long stall, R4 random mfc elsewhere
    run_instr(3, 1'b1, 1);   // R6 taken
    run_instr(3, 1'b0, 2);   // R6 not taken
    run_instr(0, 1'b0, 0);   // R8 undefined
    run_instr(1, 1'b1, 3);   // R8 flag stays set
    run_instr(15, 1'b0, 1);
    // random
    for (int k = 0; k < 60; k++)
      run_instr(int'($urandom % 16), 1'($urandom % 2), int'($urandom % 6));
    step(0, 1'b0, 0, "R7 final return");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule